// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block is the digital successive-approximation controller for a 10-bit differential charge-redistribution converter that samples its input on the capacitor top plates. It runs from one system clock at twelve times the sample rate and frames each conversion with an internal cycle counter. The block generates its own sample control. It then drives the DAC switch controls through one sampling cycle, one idle settling cycle and ten bit decisions, from the most significant bit down to the least.

During sampling, the DAC control word holds the most significant bit at 1 and every other bit at 0. The first decision therefore only keeps or clears that bit. Each later decision cycle trials the next lower bit at 1, and the comparator's verdict keeps or clears it. The comparator decision is held stable for the whole cycle, and the sequencer takes it at the closing clock edge. When a frame completes, the block copies the finished code to a result register and flags it with a one-cycle strobe.

Top module: `sar_conv_sequencer`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) puts the block in the sampling cycle with the DAC controls at the preset pattern 10'b10_0000_0000, the result at 0 and the valid strobe low.
- R2: A frame is 12 clock cycles, numbered 0 to 11. sampleCtl is high in cycle 0 and low in every other cycle.
- R3: In cycles 0 and 1 the DAC controls hold the preset pattern 10'b10_0000_0000. Any comparator value presented in these cycles has no effect.
- R4: cmpClkEn is high in cycles 2 to 11 and low in cycles 0 and 1.
- R5: In cycle k (2 to 11), DAC bit 11-k is 1 as its trial, all lower bits are 0, and all higher bits hold the decisions already made.
- R6: The comparator input sampled at the end of cycle k sets the final value of bit 11-k: 1 keeps the bit and 0 clears it.
- R7: In cycle 0 of the next frame, result carries the completed 10-bit code and resultValid is high for exactly that one cycle.
- R8: result changes only when resultValid is high and holds its value through the rest of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twelve times the sample rate |
| rst | input | 1 | Synchronous reset, active high |
| cmpDecision | input | 1 | Latched comparator verdict; 1 means the positive DAC output is above the negative one |
| sampleCtl | output | 1 | Top-plate sampling switch control |
| dacBits | output | 10 | DAC switch controls, bit 9 is the MSB |
| cmpClkEn | output | 1 | Comparator clock enable |
| result | output | 10 | Last completed conversion code |
| resultValid | output | 1 | One-cycle strobe marking a new result |

## Verification
On every cycle, the assertions check the frame position of the sample pulse and of the comparator enable against an independent cycle count. They also check the preset pattern during sampling, that the trial bit is set with clear bits below it during decisions, that the valid strobe lasts one cycle, and that the result holds between strobes. Whether each decision lands on the right bit, and whether the final code matches the analog level, depends on the comparator's answers. Only the bench's scenarios can show this, using an ideal comparator model over codes at both ends of the range and alternating bit patterns. The same applies to reset partway through a frame and to a noisy comparator during the idle cycles.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  localparam int IDX_W = 4;

  typedef struct packed {
    logic             sample;
    logic             decide;
    logic             lastBit;
    logic [IDX_W-1:0] bitIdx;
  } seqStrobes_t;
endpackage

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int NBITS = 10
) (
  input  logic        clk,
  input  logic        rst,
  output seqStrobes_t strobes
);
  localparam int FRAME = NBITS + 2;
  localparam int CW    = $clog2(FRAME);
  localparam logic [CW-1:0] LAST = CW'(FRAME - 1);

  logic [CW-1:0] cycQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      cycQ <= '0;
    end else if (cycQ == LAST) begin
      cycQ <= '0;
    end else begin
      cycQ <= cycQ + 1'b1;
    end
  end

  always_comb begin
    strobes.sample  = (cycQ == '0);
    strobes.decide  = (cycQ >= CW'(2));
    strobes.lastBit = (cycQ == LAST);
    strobes.bitIdx  = IDX_W'(NBITS + 1) - IDX_W'(cycQ);
  end
endmodule

// File: rtl/sar_seq_dpath.sv
module sar_seq_dpath
  import sar_seq_pkg::*;
#(
  parameter int NBITS = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  seqStrobes_t      strobes,
  input  logic             cmpBit,
  output logic [NBITS-1:0] dacQ,
  output logic [NBITS-1:0] resultQ,
  output logic             validQ
);
  localparam logic [NBITS-1:0] PRESET = {1'b1, {(NBITS-1){1'b0}}};

  logic [NBITS-1:0] decided;
  logic [NBITS-1:0] nextTrial;

  always_comb begin
    decided = dacQ;
    decided[strobes.bitIdx] = cmpBit;
    nextTrial = decided;
    if (!strobes.lastBit) begin
      nextTrial[strobes.bitIdx - 1'b1] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dacQ    <= PRESET;
      resultQ <= '0;
      validQ  <= 1'b0;
    end else begin
      validQ <= 1'b0;
      if (strobes.decide) begin
        if (strobes.lastBit) begin
          resultQ <= decided;
          validQ  <= 1'b1;
          dacQ    <= PRESET;
        end else begin
          dacQ <= nextTrial;
        end
      end
    end
  end
endmodule

// File: rtl/sar_conv_sequencer.sv
module sar_conv_sequencer
  import sar_seq_pkg::*;
#(
  parameter int NBITS = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmpDecision,
  output logic             sampleCtl,
  output logic [NBITS-1:0] dacBits,
  output logic             cmpClkEn,
  output logic [NBITS-1:0] result,
  output logic             resultValid
);
  seqStrobes_t strobes;

  sar_seq_ctrl #(.NBITS(NBITS)) uCtrl (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes)
  );

  sar_seq_dpath #(.NBITS(NBITS)) uDpath (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .cmpBit  (cmpDecision),
    .dacQ    (dacBits),
    .resultQ (result),
    .validQ  (resultValid)
  );

  assign sampleCtl = strobes.sample;
  assign cmpClkEn  = strobes.decide;
endmodule

// File: rtl/sar_conv_sequencer_chk.sv
module sar_conv_sequencer_chk #(
  parameter int NBITS = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             sampleCtl,
  input logic [NBITS-1:0] dacBits,
  input logic             cmpClkEn,
  input logic [NBITS-1:0] result,
  input logic             resultValid
);
  localparam int FRAME = NBITS + 2;
  localparam logic [NBITS-1:0] PRESET = {1'b1, {(NBITS-1){1'b0}}};

  int unsigned frameCyc;
  int unsigned trialIdx;
  logic [NBITS-1:0] lowMask;

  always_ff @(posedge clk) begin
    if (rst) frameCyc <= 0;
    else if (frameCyc == FRAME - 1) frameCyc <= 0;
    else frameCyc <= frameCyc + 1;
  end

  always_comb begin
    trialIdx = NBITS + 1 - frameCyc;
    lowMask  = NBITS'((64'd1 << trialIdx) - 64'd1);
  end

  a_r2_sample_position: assert property (@(posedge clk) disable iff (rst)
    sampleCtl == (frameCyc == 0));
  a_r3_preset_in_sampling: assert property (@(posedge clk) disable iff (rst)
    (frameCyc < 2) |-> dacBits == PRESET);
  a_r4_enable_window: assert property (@(posedge clk) disable iff (rst)
    cmpClkEn == (frameCyc >= 2));
  a_r5_trial_bit_set: assert property (@(posedge clk) disable iff (rst)
    cmpClkEn |-> (dacBits[trialIdx] && ((dacBits & lowMask) == '0)));
  a_r7_valid_one_cycle: assert property (@(posedge clk) disable iff (rst)
    resultValid |-> (sampleCtl && frameCyc == 0));
  a_r7_valid_drops: assert property (@(posedge clk) disable iff (rst)
    resultValid |=> !resultValid);
  a_r8_result_holds: assert property (@(posedge clk) disable iff (rst)
    !resultValid |-> $stable(result));
endmodule

bind sar_conv_sequencer sar_conv_sequencer_chk #(.NBITS(NBITS)) uChk (
  .clk         (clk),
  .rst         (rst),
  .sampleCtl   (sampleCtl),
  .dacBits     (dacBits),
  .cmpClkEn    (cmpClkEn),
  .result      (result),
  .resultValid (resultValid)
);

// File: tb/tb_sar_conv_sequencer.sv
module tb_sar_conv_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 10;
  localparam int NVEC = 8;
  localparam logic [NB-1:0] PRESET = 10'h200;
  localparam logic [NB-1:0] VEC [NVEC] = '{10'd0, 10'd1023, 10'd512, 10'd511,
                                          10'd341, 10'd682, 10'd1, 10'd600};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmpDecision = 1'b0;
  logic sampleCtl, cmpClkEn, resultValid;
  logic [NB-1:0] dacBits, result;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sar_conv_sequencer #(.NBITS(NB)) dut (
    .clk(clk), .rst(rst), .cmpDecision(cmpDecision), .sampleCtl(sampleCtl),
    .dacBits(dacBits), .cmpClkEn(cmpClkEn), .result(result), .resultValid(resultValid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Entered at the falling edge inside cycle 0; leaves at cycle 0 of the next frame.
  task automatic runFrame(input logic [NB-1:0] x, input bit expValid,
                          input logic [NB-1:0] prevRes, input bit noise);
    for (int c = 0; c < 12; c++) begin
      check(sampleCtl == (c == 0), "R2 sample", sampleCtl, c == 0);
      check(cmpClkEn == (c >= 2), "R4 enable", cmpClkEn, c >= 2);
      check(resultValid == (c == 0 && expValid), "R7 valid", resultValid, c == 0 && expValid);
      check(result == prevRes, "R8 result hold", result, prevRes);
      if (c < 2) begin
        check(dacBits == PRESET, "R3 preset", dacBits, PRESET);
        cmpDecision = noise;
      end else begin
        int idx = 11 - c;
        logic [NB-1:0] hiMask = ~NB'((11'd1 << (idx + 1)) - 11'd1);
        logic [NB-1:0] trial = (x & hiMask) | NB'(11'd1 << idx);
        check(dacBits == trial, "R5 trial", dacBits, trial);
        cmpDecision = (x >= dacBits); // R6 ideal comparator: 1 keeps bit
      end
      @(negedge clk);
    end
    check(result == x, "R6 R7 code", result, x);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [NB-1:0] prev;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(sampleCtl == 1'b1, "R1 sample", sampleCtl, 1);
    check(dacBits == PRESET, "R1 dac", dacBits, PRESET);
    check(result == '0, "R1 result", result, 0);
    check(resultValid == 1'b0, "R1 valid", resultValid, 0);

    prev = '0;
    for (int v = 0; v < NVEC; v++) begin
      runFrame(VEC[v], v != 0, prev, v[0]);
      prev = VEC[v];
    end

    // R1 reset in the middle of a frame
    cmpDecision = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check(sampleCtl == 1'b1, "R1 mid-frame sample", sampleCtl, 1);
    check(dacBits == PRESET, "R1 mid-frame dac", dacBits, PRESET);
    check(result == '0, "R1 mid-frame result", result, 0);
    check(cmpClkEn == 1'b0, "R1 mid-frame enable", cmpClkEn, 0);

    // R3 noisy comparator during sampling and idle, then back-to-back frames
    runFrame(10'd0, 1'b0, '0, 1'b1);
    runFrame(10'h155, 1'b1, 10'd0, 1'b1);
    runFrame(10'h3FE, 1'b1, 10'h155, 1'b0);
    check(resultValid == 1'b1, "R7 final valid", resultValid, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule